// File: doc/BRIEF.md
# Quad Transceiver Lane Control Register Block

This block holds the software-visible controls of one four-lane serial transceiver quad. A control word carries a lane-select field and a power-down bit. Four kinds of per-lane configuration register follow it: transmit setting A, transmit setting B, receive setting and receive equaliser setting. Each kind has four physical lane copies that drive the analog lanes, plus one readable copy that holds the last word software wrote to that address.

The lane select decides where a write to a per-lane register lands. A value from 0 to 3 names one lane. The broadcast value 16 updates all four lanes in the same cycle. Any other value leaves every lane untouched. A read never depends on the select: it returns the readable copy. The power-down bit drives the lane power state and the clock-multiplier power, and it produces one-cycle requests to the link state machine. These requests send the link back to detect, or start training once the quad has powered up and initialised. The lane-select and power-down fields survive a software reset. All per-lane registers are cleared by it.

Top module: `quad_lane_regs`

## Requirements
- R1: After a full reset, the control word reads 0x00000010 (select 16, power-down 0), every lane output and readable copy is zero, and `rdata` is zero.
- R2: A per-lane write made while the select (control bits 4:0) is 0, 1, 2 or 3 updates only that lane of the addressed kind in the next cycle. Lane n occupies bits n*32+31 down to n*32 of its output.
- R3: A per-lane write made while the select is 16 updates all four lanes of the addressed kind in the same cycle.
- R4: A per-lane write made while the select is any other value changes no lane, but it does update the readable copy of that address.
- R5: The word addresses are control 0, transmit A 1, transmit B 2, receive 3 and equaliser 4. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read. A per-lane read returns the last value written to that address. A read and a write in the same cycle return the value from before the write.
- R6: Control bits 31:6 read as zero and ignore writes. Addresses 5 and above read as zero, and writes to them change nothing.
- R7: A control write that sets bit 5 puts all lanes in P2 (`lane_p2` all ones) and turns on `cmu_pd` in the next cycle. If the quad was powered and the port is enabled, it also raises `link_to_detect` for exactly that one cycle. A write that finds the quad already off gives no pulse.
- R8: When power-down is clear and the port is enabled, the quad leaves the off state and spends INIT_CYCLES cycles initialising, with `cmu_pd` low and lanes still in P2. It then releases `lane_p2` and raises `link_train_req` for one cycle.
- R9: While `port_disabled` is high, `cmu_pd` and every `lane_p2` bit are high and no `link_to_detect` or `link_train_req` pulse occurs. After it falls with power-down clear, the power-up sequence of R8 follows.
- R10: `soft_rst` clears all lane copies and readable copies and takes priority over a per-lane write in the same cycle. The select and power-down fields keep their values, and a control write in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| soft_rst | input | 1 | Software-initiated reset; the sticky fields are kept |
| port_disabled | input | 1 | The associated port is disabled; the quad stays off |
| addr | input | ADDR_W | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one cycle after `rd_en` |
| tx0_cfg | output | NUM_LANES*DATA_W | Transmit setting A, one word per lane |
| tx1_cfg | output | NUM_LANES*DATA_W | Transmit setting B, one word per lane |
| rx_cfg | output | NUM_LANES*DATA_W | Receive setting, one word per lane |
| rxeq_cfg | output | NUM_LANES*DATA_W | Receive equaliser setting, one word per lane |
| lane_p2 | output | NUM_LANES | Lane held in the P2 low-power state |
| cmu_pd | output | 1 | Clock multiplier powered down |
| link_to_detect | output | 1 | One-cycle request to return the link to detect |
| link_train_req | output | 1 | One-cycle request to start link training |

## Verification
Two pairs of functions can meet in one cycle. A read can land on the same address as a write, and a software reset can coincide with a per-lane or control write. The bench provokes both pairs in directed steps. It also provokes them in a long pseudo-random phase where read, write, soft reset and port-disable strobes are drawn independently. A behavioural model with read-before-write and reset-over-write ordering is compared against every output on every clock. Simultaneous power-down writes and port-disable changes are judged the same way, through the pulse outputs.

// File: rtl/qlr_pkg.sv
package qlr_pkg;
   // number of distinct per-lane register kinds behind the control word
   localparam int unsigned NUM_KINDS  = 4;
   // word address of the control word; kinds follow it contiguously
   localparam int unsigned ADDR_CTRL  = 0;
   localparam int unsigned ADDR_KIND0 = 1;

   typedef enum logic [1:0] {
      PWR_OFF  = 2'd0,
      PWR_INIT = 2'd1,
      PWR_ON   = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/qlr_lane_bank.sv
module qlr_lane_bank #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SEL_W     = 5,
   parameter int unsigned BCAST_SEL = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        soft_rst,
   input  logic                        wr_hit,
   input  logic [SEL_W-1:0]            lane_sel,
   input  logic [DATA_W-1:0]           wdata,
   output logic [NUM_LANES*DATA_W-1:0] lanes_q,
   output logic [DATA_W-1:0]           shadow_q
);
   logic bcast;
   assign bcast = (lane_sel == SEL_W'(BCAST_SEL));

   // readable copy: follows every write, whatever the select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shadow_q <= '0;
      else if (soft_rst) shadow_q <= '0;
      else if (wr_hit)   shadow_q <= wdata;
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic              hit;
      logic [DATA_W-1:0] word_q;
      assign hit = wr_hit && (bcast || (lane_sel == SEL_W'(l)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        word_q <= '0;
         else if (soft_rst) word_q <= '0;
         else if (hit)      word_q <= wdata;
      end
      assign lanes_q[l*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/qlr_ctrl.sv
module qlr_ctrl
   import qlr_pkg::*;
#(
   parameter int unsigned NUM_LANES   = 4,
   parameter int unsigned SEL_W       = 5,
   parameter int unsigned RESET_SEL   = 16,
   parameter int unsigned INIT_CYCLES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr,
   input  logic [SEL_W:0]       ctrl_wdata,
   input  logic                 port_disabled,
   output logic [SEL_W-1:0]     lane_sel_q,
   output logic                 pd_q,
   output logic [NUM_LANES-1:0] lane_p2,
   output logic                 cmu_pd,
   output logic                 to_detect_q,
   output logic                 train_req_q
);
   localparam int unsigned CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
   localparam int unsigned PD_BIT = SEL_W;

   logic [SEL_W-1:0] sel_d;
   logic             pd_d;
   pwr_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             train_d, detect_d;

   always_comb begin
      sel_d = ctrl_wr ? ctrl_wdata[SEL_W-1:0] : lane_sel_q;
      pd_d  = ctrl_wr ? ctrl_wdata[PD_BIT]    : pd_q;
   end

   // sticky fields: only the full reset returns them to default
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_sel_q <= SEL_W'(RESET_SEL);
         pd_q       <= 1'b0;
      end else begin
         lane_sel_q <= sel_d;
         pd_q       <= pd_d;
      end
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      train_d = 1'b0;
      if (pd_d || port_disabled) begin
         state_d = PWR_OFF;
      end else begin
         unique case (state_q)
            PWR_OFF: begin
               state_d = PWR_INIT;
               cnt_d   = '0;
            end
            PWR_INIT: begin
               if (cnt_q == CNT_W'(INIT_CYCLES - 1)) begin
                  state_d = PWR_ON;
                  train_d = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // return-to-detect fires on a power-down write that finds the quad live
   assign detect_d = ctrl_wr && ctrl_wdata[PD_BIT] && !port_disabled && (state_q != PWR_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PWR_OFF;
         cnt_q       <= '0;
         to_detect_q <= 1'b0;
         train_req_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         cnt_q       <= cnt_d;
         to_detect_q <= detect_d;
         train_req_q <= train_d;
      end
   end

   assign cmu_pd = (state_q == PWR_OFF) || port_disabled;
   for (genvar l = 0; l < NUM_LANES; l++) begin : g_p2
      assign lane_p2[l] = (state_q != PWR_ON) || port_disabled;
   end
endmodule

// File: rtl/qlr_read_port.sv
module qlr_read_port
   import qlr_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           ctrl_word,
   input  logic [NUM_KINDS*DATA_W-1:0] shadows,
   output logic [DATA_W-1:0]           rdata
);
   logic [DATA_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      if (addr == ADDR_W'(ADDR_CTRL)) sel_word = ctrl_word;
      for (int k = 0; k < NUM_KINDS; k++) begin
         if (addr == ADDR_W'(ADDR_KIND0 + k)) sel_word = shadows[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel_word;
   end
endmodule

// File: rtl/quad_lane_regs.sv
module quad_lane_regs
   import qlr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_LANES   = 4,
   parameter int unsigned SEL_W       = 5,
   parameter int unsigned BCAST_SEL   = 16,
   parameter int unsigned RESET_SEL   = 16,
   parameter int unsigned INIT_CYCLES = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        soft_rst,
   input  logic                        port_disabled,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [NUM_LANES*DATA_W-1:0] tx0_cfg,
   output logic [NUM_LANES*DATA_W-1:0] tx1_cfg,
   output logic [NUM_LANES*DATA_W-1:0] rx_cfg,
   output logic [NUM_LANES*DATA_W-1:0] rxeq_cfg,
   output logic [NUM_LANES-1:0]        lane_p2,
   output logic                        cmu_pd,
   output logic                        link_to_detect,
   output logic                        link_train_req
);
   localparam int unsigned LANE_VEC_W = NUM_LANES * DATA_W;
   localparam int unsigned LAST_ADDR  = ADDR_KIND0 + NUM_KINDS - 1;

   // elaboration-time parameter checks
   if (DATA_W < SEL_W + 1) begin : g_bad_data_w
      $error("DATA_W too narrow for select and power-down fields");
   end
   if (BCAST_SEL < NUM_LANES || BCAST_SEL >= (1 << SEL_W)) begin : g_bad_bcast
      $error("BCAST_SEL must lie above the lane numbers and fit SEL_W");
   end
   if (RESET_SEL >= (1 << SEL_W)) begin : g_bad_reset_sel
      $error("RESET_SEL does not fit SEL_W");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W cannot reach every register");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least one");
   end

   logic                        ctrl_wr;
   logic [SEL_W-1:0]            lane_sel_q;
   logic                        pd_q;
   logic [DATA_W-1:0]           ctrl_word;
   logic [NUM_KINDS-1:0][LANE_VEC_W-1:0] lanes_all;
   logic [NUM_KINDS*DATA_W-1:0] shadows;

   assign ctrl_wr = wr_en && (addr == ADDR_W'(ADDR_CTRL));

   qlr_ctrl #(
      .NUM_LANES  (NUM_LANES),
      .SEL_W      (SEL_W),
      .RESET_SEL  (RESET_SEL),
      .INIT_CYCLES(INIT_CYCLES)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .ctrl_wdata   (wdata[SEL_W:0]),
      .port_disabled(port_disabled),
      .lane_sel_q   (lane_sel_q),
      .pd_q         (pd_q),
      .lane_p2      (lane_p2),
      .cmu_pd       (cmu_pd),
      .to_detect_q  (link_to_detect),
      .train_req_q  (link_train_req)
   );

   always_comb begin
      ctrl_word              = '0;
      ctrl_word[SEL_W-1:0]   = lane_sel_q;
      ctrl_word[SEL_W]       = pd_q;
   end

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(ADDR_KIND0 + k));
      qlr_lane_bank #(
         .NUM_LANES(NUM_LANES),
         .DATA_W   (DATA_W),
         .SEL_W    (SEL_W),
         .BCAST_SEL(BCAST_SEL)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .soft_rst(soft_rst),
         .wr_hit  (hit),
         .lane_sel(lane_sel_q),
         .wdata   (wdata),
         .lanes_q (lanes_all[k]),
         .shadow_q(shadows[k*DATA_W +: DATA_W])
      );
   end

   assign tx0_cfg  = lanes_all[0];
   assign tx1_cfg  = lanes_all[1];
   assign rx_cfg   = lanes_all[2];
   assign rxeq_cfg = lanes_all[3];

   qlr_read_port #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .ctrl_word(ctrl_word),
      .shadows  (shadows),
      .rdata    (rdata)
   );
endmodule

// File: rtl/qlr_checker.sv
module qlr_checker #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned SEL_W     = 5,
   parameter int unsigned BCAST_SEL = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        soft_rst,
   input logic                        port_disabled,
   input logic [ADDR_W-1:0]           addr,
   input logic                        wr_en,
   input logic                        rd_en,
   input logic [DATA_W-1:0]           wdata,
   input logic [DATA_W-SEL_W-2:0]     rdata_hi,
   input logic [NUM_LANES*DATA_W-1:0] tx0_cfg,
   input logic [NUM_LANES*DATA_W-1:0] rx_cfg,
   input logic [NUM_LANES-1:0]        lane_p2,
   input logic                        cmu_pd,
   input logic                        link_to_detect,
   input logic                        link_train_req,
   input logic [SEL_W-1:0]            lane_sel_q,
   input logic                        pd_q
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_TX0  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(3);

   assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_RX && lane_sel_q < SEL_W'(NUM_LANES) && !soft_rst)
      |=> rx_cfg[int'($past(lane_sel_q))*DATA_W +: DATA_W] == $past(wdata));

   assert_bcast_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_TX0 && lane_sel_q == SEL_W'(BCAST_SEL) && !soft_rst)
      |=> tx0_cfg == {NUM_LANES{$past(wdata)}});

   assert_reserved_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_RX && lane_sel_q >= SEL_W'(NUM_LANES)
       && lane_sel_q != SEL_W'(BCAST_SEL) && !soft_rst)
      |=> $stable(rx_cfg));

   assert_ctrl_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_CTRL) |=> rdata_hi == '0);

   assert_detect_powered_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_to_detect |-> (cmu_pd && (&lane_p2)));

   assert_detect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_to_detect |=> !link_to_detect);

   assert_train_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      link_train_req |-> (!cmu_pd && lane_p2 == '0 && !pd_q));

   assert_disabled_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      port_disabled |-> (cmu_pd && (&lane_p2)));

   assert_disabled_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_to_detect || link_train_req) |-> !$past(port_disabled));

   assert_soft_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx0_cfg == '0 && rx_cfg == '0));

   assert_sticky_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !(wr_en && addr == A_CTRL)) |=> ($stable(lane_sel_q) && $stable(pd_q)));
endmodule

bind quad_lane_regs qlr_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_LANES(NUM_LANES),
   .SEL_W    (SEL_W),
   .BCAST_SEL(BCAST_SEL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .soft_rst      (soft_rst),
   .port_disabled (port_disabled),
   .addr          (addr),
   .wr_en         (wr_en),
   .rd_en         (rd_en),
   .wdata         (wdata),
   .rdata_hi      (rdata[DATA_W-1:SEL_W+1]),
   .tx0_cfg       (tx0_cfg),
   .rx_cfg        (rx_cfg),
   .lane_p2       (lane_p2),
   .cmu_pd        (cmu_pd),
   .link_to_detect(link_to_detect),
   .link_train_req(link_train_req),
   .lane_sel_q    (lane_sel_q),
   .pd_q          (pd_q)
);

// File: tb/quad_lane_regs_tb.sv
`timescale 1ns/1ps
module quad_lane_regs_tb;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int NL = 4;
   localparam int INIT = 8;
   localparam int PERIOD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic port_disabled = 1'b0;
   logic [AW-1:0] addr = '0;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NL*DW-1:0] tx0_cfg, tx1_cfg, rx_cfg, rxeq_cfg;
   logic [NL-1:0] lane_p2;
   logic cmu_pd, link_to_detect, link_train_req;

   always #(PERIOD/2) clk = ~clk;

   quad_lane_regs #(.INIT_CYCLES(INIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_disabled(port_disabled),
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .tx0_cfg(tx0_cfg), .tx1_cfg(tx1_cfg), .rx_cfg(rx_cfg), .rxeq_cfg(rxeq_cfg),
      .lane_p2(lane_p2), .cmu_pd(cmu_pd),
      .link_to_detect(link_to_detect), .link_train_req(link_train_req)
   );

   int n_checks = 0;
   int n_err = 0;
   int det_cnt = 0;
   int train_cnt = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_lane [4][NL];
   logic [31:0] m_shadow [4];
   logic [4:0]  m_sel;
   logic        m_pd;
   int          m_state;   // 0 off, 1 initialising, 2 powered
   int          m_cnt;
   logic        m_det, m_train;
   logic [31:0] m_rdata;
   logic [4:0]  t_sel;
   logic        t_pd;

   function automatic logic [31:0] model_read(input logic [AW-1:0] a);
      if (a == 0) return {26'b0, m_pd, m_sel};
      if (a >= 1 && a <= 4) return m_shadow[a-1];
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin
            m_shadow[k] = '0;
            for (int l = 0; l < NL; l++) m_lane[k][l] = '0;
         end
         m_sel = 5'h10; m_pd = 1'b0; m_state = 0; m_cnt = 0;
         m_det = 1'b0; m_train = 1'b0; m_rdata = '0;
      end else begin
         if (rd_en) m_rdata = model_read(addr);
         m_det = wr_en && addr == 0 && wdata[5] && !port_disabled && m_state != 0;
         t_sel = m_sel; t_pd = m_pd;
         if (wr_en && addr == 0) begin t_sel = wdata[4:0]; t_pd = wdata[5]; end
         if (soft_rst) begin
            for (int k = 0; k < 4; k++) begin
               m_shadow[k] = '0;
               for (int l = 0; l < NL; l++) m_lane[k][l] = '0;
            end
         end else if (wr_en && addr >= 1 && addr <= 4) begin
            m_shadow[addr-1] = wdata;
            if (m_sel < NL) m_lane[addr-1][m_sel] = wdata;
            else if (m_sel == 5'h10)
               for (int l = 0; l < NL; l++) m_lane[addr-1][l] = wdata;
         end
         m_sel = t_sel; m_pd = t_pd;
         m_train = 1'b0;
         if (t_pd || port_disabled) m_state = 0;
         else if (m_state == 0) begin m_state = 1; m_cnt = 0; end
         else if (m_state == 1) begin
            if (m_cnt == INIT - 1) begin m_state = 2; m_train = 1'b1; end
            else m_cnt++;
         end
      end
   end

   function automatic logic [31:0] dut_lane(input int k, input int l);
      case (k)
         0: return tx0_cfg[l*32 +: 32];
         1: return tx1_cfg[l*32 +: 32];
         2: return rx_cfg[l*32 +: 32];
         default: return rxeq_cfg[l*32 +: 32];
      endcase
   endfunction

   // per-cycle comparison, a quarter period after the edge
   always begin
      @(posedge clk);
      #(PERIOD/4);
      if (rst_n) begin
         if (link_to_detect) det_cnt++;
         if (link_train_req) train_cnt++;
         chk("R5 rdata vs model", rdata, m_rdata);
         for (int k = 0; k < 4; k++)
            for (int l = 0; l < NL; l++)
               chk("R2 lane word vs model", dut_lane(k, l), m_lane[k][l]);
         chk("R7 lane_p2 vs model", {28'b0, lane_p2},
             {28'b0, ((m_state != 2) || port_disabled) ? 4'hF : 4'h0});
         chk("R7 cmu_pd vs model", {31'b0, cmu_pd}, {31'b0, (m_state == 0) || port_disabled});
         chk("R7 link_to_detect vs model", {31'b0, link_to_detect}, {31'b0, m_det});
         chk("R8 link_train_req vs model", {31'b0, link_train_req}, {31'b0, m_train});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic bus_rw(input logic [AW-1:0] a, input logic [31:0] wd, output logic [31:0] d);
      @(negedge clk); addr = a; wdata = wd; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_checks++; n_err++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int b;
      logic [31:0] lfsr;
      idle(3);
      chk("R1 rdata in reset", rdata, 32'h0);
      chk("R1 tx0 lane0 in reset", tx0_cfg[31:0], 32'h0);
      chk("R1 rxeq lane3 in reset", rxeq_cfg[127:96], 32'h0);
      rst_n = 1'b1;
      bus_rd(0, d); chk("R1 control word default", d, 32'h0000_0010);
      for (int k = 1; k <= 4; k++) begin
         bus_rd(AW'(k), d); chk("R1 readable copy default", d, 32'h0);
      end
      idle(INIT + 4);
      chk("R8 training request after power-up", train_cnt, 1);
      chk("R8 lanes out of P2", {28'b0, lane_p2}, 32'h0);

      bus_wr(1, 32'hA5A5_0001);
      for (int l = 0; l < NL; l++) chk("R3 broadcast reaches every lane", tx0_cfg[l*32 +: 32], 32'hA5A5_0001);

      bus_wr(0, 32'h0000_0002);
      bus_wr(3, 32'h1234_5678);
      chk("R2 selected lane 2 written", rx_cfg[95:64], 32'h1234_5678);
      chk("R2 lane 0 untouched", rx_cfg[31:0], 32'h0);
      bus_rd(3, d); chk("R5 read returns last write", d, 32'h1234_5678);

      bus_wr(0, 32'h0000_0007);
      bus_wr(2, 32'hDEAD_BEEF);
      chk("R4 reserved select leaves lanes", tx1_cfg, 32'h0);
      bus_rd(2, d); chk("R4 readable copy still updated", d, 32'hDEAD_BEEF);

      bus_rw(3, 32'h0BAD_F00D, d); chk("R5 read beside write returns old", d, 32'h1234_5678);
      bus_rd(3, d); chk("R5 later read returns new", d, 32'h0BAD_F00D);
      chk("R4 lane 2 kept under reserved select", rx_cfg[95:64], 32'h1234_5678);

      b = det_cnt;
      bus_wr(0, 32'hFFFF_FFE1);
      chk("R7 one detect pulse on power-down", det_cnt, b + 1);
      chk("R7 clock multiplier off", {31'b0, cmu_pd}, 32'h1);
      chk("R7 lanes in P2", {28'b0, lane_p2}, 32'hF);
      bus_rd(0, d); chk("R6 upper control bits read zero", d, 32'h0000_0021);
      bus_wr(0, 32'h0000_0021);
      chk("R7 no pulse when already off", det_cnt, b + 1);

      bus_wr(9, 32'hFFFF_FFFF);
      bus_rd(9, d); chk("R6 unmapped address reads zero", d, 32'h0);

      b = train_cnt;
      bus_wr(0, 32'h0000_0010);
      idle(INIT + 2);
      chk("R8 training after power-down cleared", train_cnt, b + 1);

      @(negedge clk); port_disabled = 1'b1;
      idle(2);
      chk("R9 disabled port keeps quad off", {31'b0, cmu_pd}, 32'h1);
      b = det_cnt;
      bus_wr(0, 32'h0000_0030);
      chk("R9 no detect pulse while disabled", det_cnt, b);
      b = train_cnt;
      bus_wr(0, 32'h0000_0010);
      idle(INIT + 3);
      chk("R9 no training while disabled", train_cnt, b);
      @(negedge clk); port_disabled = 1'b0;
      idle(INIT + 3);
      chk("R9 training after enable", train_cnt, b + 1);

      bus_wr(1, 32'h0000_0055);
      bus_wr(0, 32'h0000_0003);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      bus_rd(0, d); chk("R10 sticky fields survive soft reset", d, 32'h0000_0003);
      bus_rd(1, d); chk("R10 readable copy cleared", d, 32'h0);
      chk("R10 lane copies cleared", tx0_cfg[127:96], 32'h0);
      @(negedge clk); soft_rst = 1'b1; addr = 1; wdata = 32'h77; wr_en = 1'b1;
      @(negedge clk); soft_rst = 1'b0; wr_en = 1'b0;
      chk("R10 soft reset beats lane write", tx0_cfg[127:96], 32'h0);

      // mixed traffic; the model judges every cycle
      lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         addr = AW'(lfsr[10:8] % 6);
         wr_en = lfsr[3];
         rd_en = lfsr[5];
         soft_rst = (lfsr[15:12] == 4'hA);
         if (lfsr[20:16] == 5'h3) port_disabled = ~port_disabled;
         wdata = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         if (addr == 0) begin
            case (lfsr[2:0])
               3'd0: wdata[4:0] = 5'd0;
               3'd1: wdata[4:0] = 5'd1;
               3'd2: wdata[4:0] = 5'd2;
               3'd3: wdata[4:0] = 5'd3;
               3'd4: wdata[4:0] = 5'd9;
               default: wdata[4:0] = 5'h10;
            endcase
            wdata[5] = (lfsr[7:4] == 4'h0);
         end
      end
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; soft_rst = 1'b0;
      idle(4);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule